// File: doc/BRIEF.md
# Clock and Reset Sequencer

This block sits between a free-running oscillator and the rest of a processor subsystem. It halves the oscillator frequency to form the system clock, turns an asynchronous active-low reset request into a clean active-high reset that is aligned to the system clock, and tells the processor core when it may begin its first instruction fetch. While the reset output is high, the core is expected to abandon its current work and clear its internal state.

The reset request is sampled only on oscillator edges where the system clock rises. It passes through a chain of synchronizing stages, so the reset output is high for exactly as many system-clock periods as there were consecutive low samples. When the synchronized reset is released, a countdown of half-periods places a single start strobe on a falling edge of the system clock, six and a half periods later. A reassertion of reset during that countdown cancels the strobe. A status output reports when the last reset pulse was too short for proper initialization.

Top module: `clkrst_sequencer`

## Requirements
- R1: `sys_clk_o` starts low, becomes high after the first rising edge of `osc_i`, and inverts on every later rising edge of `osc_i` (divide by two, 50% duty).
- R2: `rst_req_ni` is sampled only at oscillator edges where `sys_clk_o` rises, through a two-stage chain; after each such edge `sys_rst_o` equals the inverse of the sample taken at the previous such edge. Both stages start at 0, so `sys_rst_o` is high from time zero.
- R3: `sys_rst_o` changes only on oscillator edges where `sys_clk_o` rises, and after a run of N consecutive low samples it stays high for exactly N system-clock periods.
- R4: Before the first oscillator edge, `sys_rst_o` is 1 and `sys_clk_o`, `core_go_o` and `short_rst_o` are 0.
- R5: At the edge where `sys_rst_o` falls, `short_rst_o` becomes 1 if `sys_rst_o` was high for fewer than 5 system-clock periods and 0 otherwise; it returns to 0 at the edge where `sys_rst_o` next rises and holds its value at all other times.
- R6: Counting the oscillator edge where `sys_rst_o` falls as edge 0, `core_go_o` is 1 after oscillator edge 13 (a falling edge of `sys_clk_o`, 6.5 system periods later) and 0 again after edge 14.
- R7: If `sys_rst_o` rises again before edge 13 of that countdown, no `core_go_o` pulse is produced for that release.
- R8: `core_go_o` is never high while `sys_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_i | input | 1 | Oscillator input, twice the system clock frequency |
| rst_req_ni | input | 1 | Asynchronous reset request, active low |
| sys_clk_o | output | 1 | Divided system clock |
| sys_rst_o | output | 1 | Synchronized system reset, active high |
| core_go_o | output | 1 | One oscillator-period strobe allowing the first fetch |
| short_rst_o | output | 1 | Last reset pulse was shorter than the minimum length |

## Verification
The properties assume that the oscillator runs continuously from time zero and that the divider starts at its initial value, since the block has no reset of its own for the clock path; the bench clock never stops and the checker arms itself only after the first edge. The reset request is treated as fully asynchronous, so the bench changes it only between oscillator rising edges, including pulses shorter than one system period that the sampler may miss entirely, and lets the reference model decide which of them are seen. Reassertion is placed both well after and inside the fetch countdown to cover cancellation.

// File: rtl/crs_pkg.sv
package crs_pkg;

   // Kind of the next oscillator edge as seen by the system clock.
   typedef enum logic {
      PH_RISE = 1'b0,
      PH_FALL = 1'b1
   } crs_phase_e;

   // Counter width able to hold values 0 .. n-1.
   function automatic int unsigned crs_cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/crs_clk_div.sv
module crs_clk_div
   import crs_pkg::*;
(
   input  logic osc_i,
   output logic clk_o,
   output logic rise_en_o,
   output logic fall_en_o
);

   logic       div_q = 1'b0;
   crs_phase_e next_ph;

   always_ff @(posedge osc_i) begin
      div_q <= ~div_q;
   end

   assign next_ph   = div_q ? PH_FALL : PH_RISE;
   assign clk_o     = div_q;
   assign rise_en_o = (next_ph == PH_RISE);
   assign fall_en_o = (next_ph == PH_FALL);

endmodule

// File: rtl/crs_rst_sync.sv
module crs_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic osc_i,
   input  logic en_i,
   input  logic req_n_i,
   output logic sync_n_o,
   output logic release_o,
   output logic start_o
);

   logic stage_q [STAGES] = '{default: 1'b0};

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge osc_i) begin
               if (en_i) stage_q[0] <= req_n_i;
            end
         end else begin : g_next
            always_ff @(posedge osc_i) begin
               if (en_i) stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   assign sync_n_o  = stage_q[STAGES-1];
   assign release_o = en_i & ~stage_q[STAGES-1] &  stage_q[STAGES-2];
   assign start_o   = en_i &  stage_q[STAGES-1] & ~stage_q[STAGES-2];

endmodule

// File: rtl/crs_hold_monitor.sv
module crs_hold_monitor
   import crs_pkg::*;
#(
   parameter int unsigned MIN_CLKS = 5
) (
   input  logic osc_i,
   input  logic en_i,
   input  logic active_i,
   input  logic release_i,
   input  logic start_i,
   output logic short_o
);

   localparam int unsigned W = crs_cnt_w(MIN_CLKS + 1);
   localparam logic [W-1:0] SAT = W'(MIN_CLKS);

   logic [W-1:0] held_q  = '0;
   logic         short_q = 1'b0;
   logic [W:0]   held_now;

   assign held_now = {1'b0, held_q} + 1'b1;

   always_ff @(posedge osc_i) begin
      if (en_i) begin
         if (!active_i)         held_q <= '0;
         else if (held_q != SAT) held_q <= held_q + 1'b1;
      end
   end

   always_ff @(posedge osc_i) begin
      if (release_i)    short_q <= (held_now < (W+1)'(MIN_CLKS));
      else if (start_i) short_q <= 1'b0;
   end

   assign short_o = short_q;

endmodule

// File: rtl/crs_fetch_timer.sv
module crs_fetch_timer
   import crs_pkg::*;
#(
   parameter int unsigned HALF_CYCLES = 13
) (
   input  logic osc_i,
   input  logic release_i,
   input  logic abort_i,
   output logic go_o
);

   localparam int unsigned W = crs_cnt_w(HALF_CYCLES);
   localparam logic [W-1:0] LOAD = W'(HALF_CYCLES - 1);

   logic [W-1:0] left_q = '0;
   logic         busy_q = 1'b0;
   logic         go_q   = 1'b0;

   always_ff @(posedge osc_i) begin
      go_q <= 1'b0;
      if (release_i) begin
         busy_q <= 1'b1;
         left_q <= LOAD;
      end else if (abort_i) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         if (left_q == '0) begin
            go_q   <= 1'b1;
            busy_q <= 1'b0;
         end else begin
            left_q <= left_q - 1'b1;
         end
      end
   end

   assign go_o = go_q;

endmodule

// File: rtl/clkrst_sequencer.sv
module clkrst_sequencer #(
   parameter int unsigned SYNC_STAGES       = 2,
   parameter int unsigned MIN_RST_CLKS      = 5,
   parameter int unsigned FETCH_HALF_CYCLES = 13
) (
   input  logic osc_i,
   input  logic rst_req_ni,
   output logic sys_clk_o,
   output logic sys_rst_o,
   output logic core_go_o,
   output logic short_rst_o
);

   initial begin
      if (SYNC_STAGES < 2)
         $error("SYNC_STAGES must be at least 2");
      if (MIN_RST_CLKS < 1)
         $error("MIN_RST_CLKS must be at least 1");
      if ((FETCH_HALF_CYCLES % 2) != 1)
         $error("FETCH_HALF_CYCLES must be odd to land on a falling phase");
   end

   logic rise_en, fall_en;
   logic sync_n, rel, start;

   crs_clk_div u_div (
      .osc_i     (osc_i),
      .clk_o     (sys_clk_o),
      .rise_en_o (rise_en),
      .fall_en_o (fall_en)
   );

   crs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .osc_i     (osc_i),
      .en_i      (rise_en),
      .req_n_i   (rst_req_ni),
      .sync_n_o  (sync_n),
      .release_o (rel),
      .start_o   (start)
   );

   crs_hold_monitor #(.MIN_CLKS(MIN_RST_CLKS)) u_hold (
      .osc_i     (osc_i),
      .en_i      (rise_en),
      .active_i  (~sync_n),
      .release_i (rel),
      .start_i   (start),
      .short_o   (short_rst_o)
   );

   crs_fetch_timer #(.HALF_CYCLES(FETCH_HALF_CYCLES)) u_fetch (
      .osc_i     (osc_i),
      .release_i (rel),
      .abort_i   (~sync_n),
      .go_o      (core_go_o)
   );

   assign sys_rst_o = ~sync_n;

   logic unused_fall;
   assign unused_fall = fall_en;

endmodule

// File: rtl/clkrst_sequencer_chk.sv
module clkrst_sequencer_chk (
   input logic osc_i,
   input logic rst_req_ni,
   input logic sys_clk_o,
   input logic sys_rst_o,
   input logic core_go_o,
   input logic short_rst_o
);

   logic armed_q = 1'b0;
   always_ff @(posedge osc_i) armed_q <= 1'b1;

   logic unused_req;
   assign unused_req = rst_req_ni;

   assert_clk_toggles_R1: assert property (@(posedge osc_i) disable iff (!armed_q)
      sys_clk_o != $past(sys_clk_o));

   assert_rst_on_rise_R3: assert property (@(posedge osc_i) disable iff (!armed_q)
      (sys_rst_o != $past(sys_rst_o)) |-> sys_clk_o);

   assert_short_at_release_R5: assert property (@(posedge osc_i) disable iff (!armed_q)
      $rose(short_rst_o) |-> $fell(sys_rst_o));

   assert_go_fall_phase_R6: assert property (@(posedge osc_i) disable iff (!armed_q)
      core_go_o |-> !sys_clk_o);

   assert_go_single_R6: assert property (@(posedge osc_i) disable iff (!armed_q)
      core_go_o |=> !core_go_o);

   assert_go_outside_reset_R8: assert property (@(posedge osc_i) disable iff (!armed_q)
      core_go_o |-> !sys_rst_o);

endmodule

bind clkrst_sequencer clkrst_sequencer_chk u_chk (.*);

// File: tb/clkrst_sequencer_test.sv
module clkrst_sequencer_test;

   logic osc = 1'b0;
   logic rst_n = 1'b0;
   logic sys_clk, sys_rst, core_go, short_rst;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   clkrst_sequencer uut (
      .osc_i       (osc),
      .rst_req_ni  (rst_n),
      .sys_clk_o   (sys_clk),
      .sys_rst_o   (sys_rst),
      .core_go_o   (core_go),
      .short_rst_o (short_rst)
   );

   always #10 osc = ~osc;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Reference model state
   logic smp;
   int   edge_n = 0;
   bit   m_s1 = 0, m_s2 = 0, m_rst = 1, m_short = 0, m_go = 0, m_clk = 0;
   int   held = 0;
   int   due = -1;
   int   exp_pulses = 0, got_pulses = 0;
   int   rst_hist[$];

   always @(posedge osc) smp <= rst_n;

   always @(negedge osc) begin
      bit rise, prev_rst;
      rise = (edge_n % 2 == 0);
      prev_rst = m_rst;
      if (rise) begin
         if (m_rst) held++;
         m_s2 = m_s1;
         m_s1 = smp;
         m_rst = !m_s2;
         rst_hist.push_back(int'(m_rst));
         if (rst_hist.size() > 4) void'(rst_hist.pop_front());
         if (!prev_rst && m_rst) begin
            held = 0;
            m_short = 0;
         end
         if (prev_rst && !m_rst) begin
            m_short = (held < 5);
            due = edge_n + 13;
         end
      end
      if (m_rst) due = -1;
      m_go = (edge_n == due);
      m_clk = rise;
      if (m_go) exp_pulses++;
      if (core_go) got_pulses++;

      check(sys_clk == m_clk, "R1", int'(sys_clk), int'(m_clk));
      check(sys_rst == m_rst, "R2/R3", int'(sys_rst), int'(m_rst));
      check(short_rst == m_short, "R5", int'(short_rst), int'(m_short));
      check(core_go == m_go, "R6/R7", int'(core_go), int'(m_go));
      check(!(core_go && sys_rst), "R8", int'(core_go && sys_rst), 0);
      edge_n++;
   end

   task automatic wait_osc(input int n);
      repeat (n) @(negedge osc);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #5;
      // R4: state before the first oscillator edge
      check(sys_rst == 1'b1, "R4", int'(sys_rst), 1);
      check(sys_clk == 1'b0, "R4", int'(sys_clk), 0);
      check(core_go == 1'b0, "R4", int'(core_go), 0);
      check(short_rst == 1'b0, "R4", int'(short_rst), 0);

      // Long power-up reset, then full countdown (R6)
      wait_osc(24);
      rst_n = 1'b1;
      wait_osc(40);

      // Pulses of growing length, across the R5 boundary (4 vs 5 periods)
      for (int len = 1; len <= 14; len++) begin
         rst_n = 1'b0;
         wait_osc(len);
         rst_n = 1'b1;
         wait_osc(40);
      end

      // Reassertion inside the countdown (R7), several gaps
      for (int gap = 2; gap <= 12; gap++) begin
         rst_n = 1'b0;
         wait_osc(20);
         rst_n = 1'b1;
         wait_osc(gap);
         rst_n = 1'b0;
         wait_osc(16);
         rst_n = 1'b1;
         wait_osc(40);
      end

      // R6/R7 totals: pulses seen match the model, and some were expected
      check(got_pulses == exp_pulses, "R6", got_pulses, exp_pulses);
      check(exp_pulses > 0, "R6", exp_pulses, 1);
      finish_run();
   end

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

endmodule